// File: doc/BRIEF.md
# Three-Level Hysteresis Current Modulator for One Clamped Inverter Leg

This block drives one leg of a three-level inverter from a sampled current error, the reference current minus the measured compensator current. Two thresholds are compared against the signed error. The outer band `h` sets the level to +1 or −1. The inner dead band `d` returns the level to zero. When the error lies between the two thresholds, the level keeps its previous value. When the error calls for the opposite polarity, the level always spends at least one clock at zero before it gets there.

The level is then decoded into a six-bit gate vector. A run-time select chooses one of three leg structures: a diode-clamped leg with four switches, a leg clamped through a bidirectional switch pair, or an actively clamped leg with six switches. In the zero level, each structure has more than one clamp path. The current-direction input picks the path. Whenever the structure select changes, every gate is held off for one clock before the new pattern is applied. Dead-time insertion between complementary devices is left to a later stage.

Top module: `hyst3_leg_mod`

## Requirements
- R1: When the error is at least `h`, the level output becomes +1 (`lvl_o` = 2'b01) one clock later, unless the current level is −1.
- R2: When the error is at most −`h`, the level becomes −1 (`lvl_o` = 2'b11) one clock later, unless the current level is +1.
- R3: When the error lies strictly inside ±`h` and also within −`d` to +`d` inclusive, the level becomes zero (`lvl_o` = 2'b00) one clock later.
- R4: For any other error value, the level keeps its previous value.
- R5: If the current level is +1 and the error demands −1, or the current level is −1 and the error demands +1, the next level is zero. The opposite level can only follow on a later clock.
- R6: Gate bits are assigned as follows: bit0 upper outer, bit1 upper inner, bit2 lower inner, bit3 lower outer, bit4 upper clamp, bit5 lower clamp. With structure code 2'b00 (diode-clamped), +1 drives 6'b000011, −1 drives 6'b001100, and zero drives 6'b000010 or 6'b000100.
- R7: With structure code 2'b01 (bidirectional clamp), only one main switch conducts in each active level: +1 drives 6'b000001 and −1 drives 6'b001000. Zero drives 6'b000010 or 6'b000100, which are the two halves of the clamp pair.
- R8: With structure code 2'b10 (active clamp), +1 drives 6'b000011, −1 drives 6'b001100, and zero drives 6'b010010 or 6'b100100.
- R9: In the zero level, `dir_pos_i` = 1 selects the upper clamp path (the first zero pattern listed in R6 to R8), and `dir_pos_i` = 0 selects the lower clamp path.
- R10: On the clock edge where the structure select differs from the value taken on the previous edge, the gate output becomes all zeros for one clock. The new pattern follows on the next edge. The stored select resets to 2'b00.
- R11: Structure code 2'b11 keeps every gate off, whatever the level.
- R12: An active-low reset forces the level to zero and every gate off, immediately and independently of the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_i | input | ERR_W | Signed current error sample |
| band_h_i | input | ERR_W | Outer hysteresis threshold, non-negative |
| band_d_i | input | ERR_W | Inner dead-band threshold, below `band_h_i` |
| topo_sel_i | input | 2 | Leg structure select |
| dir_pos_i | input | 1 | Current direction, 1 for positive |
| gate_o | output | 6 | Registered gate vector |
| lvl_o | output | 2 | Registered level, two's complement |

## Verification
Both the level and the gate vector are registered, and the gates are decoded from the level that the same edge loads. Each result is therefore due one clock edge after the inputs that cause it. The bench changes inputs just after a rising edge and reads both outputs just after the next rising edge, before it drives anything new. The gate blanking after a structure change is checked on that first edge, and the new mapping on the edge after it. A reset applied mid-run is checked a moment later, without waiting for any edge.

// File: rtl/hyst3_pkg.sv
`timescale 1ns/1ps
package hyst3_pkg;
  localparam int GATE_W   = 6;
  localparam int TOPO_W   = 2;
  localparam int NUM_TOPO = 3;

  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b11
  } lvl_e;

  typedef enum logic [TOPO_W-1:0] {
    TOPO_DIODE  = 2'b00,
    TOPO_BIDIR  = 2'b01,
    TOPO_ACTIVE = 2'b10,
    TOPO_NONE   = 2'b11
  } topo_e;

  typedef enum logic [1:0] {
    REQ_HOLD = 2'b00,
    REQ_POS  = 2'b01,
    REQ_NEG  = 2'b10,
    REQ_ZERO = 2'b11
  } req_e;

  // next level from the present level and the band request, never jumping polarity
  function automatic lvl_e step_level(lvl_e cur, req_e rq);
    lvl_e nx;
    case (rq)
      REQ_POS:  nx = (cur == LVL_NEG) ? LVL_ZERO : LVL_POS;
      REQ_NEG:  nx = (cur == LVL_POS) ? LVL_ZERO : LVL_NEG;
      REQ_ZERO: nx = LVL_ZERO;
      default:  nx = cur;
    endcase
    return nx;
  endfunction

  // gate pattern per leg structure; bit0 up-outer, bit1 up-inner,
  // bit2 low-inner, bit3 low-outer, bit4 up-clamp, bit5 low-clamp
  function automatic logic [GATE_W-1:0] leg_pattern(topo_e t, lvl_e s, logic up);
    logic [GATE_W-1:0] g;
    g = '0;
    case (t)
      TOPO_DIODE: begin
        case (s)
          LVL_POS: g = 6'b000011;
          LVL_NEG: g = 6'b001100;
          default: g = up ? 6'b000010 : 6'b000100;
        endcase
      end
      TOPO_BIDIR: begin
        case (s)
          LVL_POS: g = 6'b000001;
          LVL_NEG: g = 6'b001000;
          default: g = up ? 6'b000010 : 6'b000100;
        endcase
      end
      TOPO_ACTIVE: begin
        case (s)
          LVL_POS: g = 6'b000011;
          LVL_NEG: g = 6'b001100;
          default: g = up ? 6'b010010 : 6'b100100;
        endcase
      end
      default: g = '0;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/hyst3_band_cmp.sv
`timescale 1ns/1ps
module hyst3_band_cmp
  import hyst3_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic signed [ERR_W-1:0] err_i,
  input  logic signed [ERR_W-1:0] band_h_i,
  input  logic signed [ERR_W-1:0] band_d_i,
  output req_e                    req_o
);
  logic signed [ERR_W-1:0] neg_h;
  logic signed [ERR_W-1:0] neg_d;
  logic hit_pos;
  logic hit_neg;
  logic in_dead;

  assign neg_h   = -band_h_i;
  assign neg_d   = -band_d_i;
  assign hit_pos = (err_i >= band_h_i);
  assign hit_neg = (err_i <= neg_h);
  assign in_dead = (err_i <= band_d_i) && (err_i >= neg_d);

  always_comb begin
    if (hit_pos)      req_o = REQ_POS;
    else if (hit_neg) req_o = REQ_NEG;
    else if (in_dead) req_o = REQ_ZERO;
    else              req_o = REQ_HOLD;
  end
endmodule

// File: rtl/hyst3_state_seq.sv
`timescale 1ns/1ps
module hyst3_state_seq
  import hyst3_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  req_e req_i,
  output lvl_e lvl_d_o,
  output lvl_e lvl_q_o
);
  lvl_e lvl_q;

  assign lvl_d_o = step_level(lvl_q, req_i);
  assign lvl_q_o = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= LVL_ZERO;
    else        lvl_q <= lvl_d_o;
  end

  AST_ENTER_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == REQ_POS && lvl_q != LVL_NEG) |=> (lvl_q == LVL_POS)); // R1
  AST_ENTER_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == REQ_NEG && lvl_q != LVL_POS) |=> (lvl_q == LVL_NEG)); // R2
  AST_DEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == REQ_ZERO) |=> (lvl_q == LVL_ZERO)); // R3
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == REQ_HOLD) |=> $stable(lvl_q)); // R4
  AST_NO_POS_TO_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LVL_POS) |=> (lvl_q != LVL_NEG)); // R5
  AST_NO_NEG_TO_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LVL_NEG) |=> (lvl_q != LVL_POS)); // R5
endmodule

// File: rtl/hyst3_gate_map.sv
`timescale 1ns/1ps
module hyst3_gate_map
  import hyst3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TOPO_W-1:0] topo_sel_i,
  input  lvl_e              lvl_nx_i,
  input  logic              dir_pos_i,
  output logic [GATE_W-1:0] gate_o
);
  logic [TOPO_W-1:0] topo_q;
  logic              topo_changed;
  logic [GATE_W-1:0] cand [NUM_TOPO];
  logic [GATE_W-1:0] pick;
  logic [GATE_W-1:0] gate_q;

  for (genvar t = 0; t < NUM_TOPO; t++) begin : g_topo
    assign cand[t] = leg_pattern(topo_e'(TOPO_W'(t)), lvl_nx_i, dir_pos_i);
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_TOPO; i++) begin
      if (topo_sel_i == TOPO_W'(i)) pick = cand[i];
    end
  end

  assign topo_changed = (topo_sel_i != topo_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      topo_q <= TOPO_DIODE;
      gate_q <= '0;
    end else begin
      topo_q <= topo_sel_i;
      gate_q <= topo_changed ? '0 : pick;
    end
  end

  assign gate_o = gate_q;

  AST_BLANK_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    topo_changed |=> (gate_q == '0)); // R10
  AST_RESERVED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (topo_q == TOPO_NONE) |-> (gate_q == '0)); // R11
  AST_OUTER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_q[0] && gate_q[3])); // R6
  AST_CLAMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_q[4] && gate_q[5])); // R8
  AST_ZERO_UPPER_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (!topo_changed && topo_sel_i != TOPO_NONE && lvl_nx_i == LVL_ZERO && dir_pos_i)
      |=> (gate_q[1] && !gate_q[2])); // R9
endmodule

// File: rtl/hyst3_leg_mod.sv
`timescale 1ns/1ps
module hyst3_leg_mod
  import hyst3_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic signed [ERR_W-1:0] band_h_i,
  input  logic signed [ERR_W-1:0] band_d_i,
  input  logic [1:0]              topo_sel_i,
  input  logic                    dir_pos_i,
  output logic [5:0]              gate_o,
  output logic [1:0]              lvl_o
);
  req_e              band_req;
  lvl_e              lvl_nx;
  lvl_e              lvl_q;
  logic [GATE_W-1:0] gate_w;

  hyst3_band_cmp #(.ERR_W(ERR_W)) u_cmp (
    .err_i    (err_i),
    .band_h_i (band_h_i),
    .band_d_i (band_d_i),
    .req_o    (band_req)
  );

  hyst3_state_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (band_req),
    .lvl_d_o (lvl_nx),
    .lvl_q_o (lvl_q)
  );

  hyst3_gate_map u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .topo_sel_i (topo_sel_i),
    .lvl_nx_i   (lvl_nx),
    .dir_pos_i  (dir_pos_i),
    .gate_o     (gate_w)
  );

  assign gate_o = gate_w;
  assign lvl_o  = lvl_q;

  AST_POS_USES_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LVL_POS && gate_w != '0) |-> (gate_w[0] && !gate_w[3])); // R7
  AST_NEG_USES_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LVL_NEG && gate_w != '0) |-> (gate_w[3] && !gate_w[0])); // R7
  AST_ZERO_NO_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LVL_ZERO) |-> (!gate_w[0] && !gate_w[3])); // R6
endmodule

// File: tb/hyst3_leg_mod_test.sv
`timescale 1ns/1ps
module hyst3_leg_mod_test;
  localparam int EW = 16;

  logic                 clk;
  logic                 rst_n;
  logic signed [EW-1:0] err;
  logic signed [EW-1:0] bh;
  logic signed [EW-1:0] bd;
  logic [1:0]           topo;
  logic                 dir;
  logic [5:0]           gate;
  logic [1:0]           lvl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hyst3_leg_mod #(.ERR_W(EW)) uut (
    .clk(clk), .rst_n(rst_n), .err_i(err), .band_h_i(bh), .band_d_i(bd),
    .topo_sel_i(topo), .dir_pos_i(dir), .gate_o(gate), .lvl_o(lvl)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int next_lvl(int prior, int e, int h, int d);
    int t;
    if (e >= h) t = 1;
    else if (e <= -h) t = -1;
    else if (e <= d && e >= -d) t = 0;
    else return prior;
    if (prior * t == -1) return 0;
    return t;
  endfunction

  function automatic logic [1:0] bits_of(int v);
    return v[1:0];
  endfunction

  function automatic logic [5:0] exp_gates(int tp, int st, bit up);
    logic [5:0] g;
    if (tp == 3) return 6'b0;
    g[0] = (st == 1);
    g[1] = (st == 1 && tp != 1) || (st == 0 && up);
    g[2] = (st == -1 && tp != 1) || (st == 0 && !up);
    g[3] = (st == -1);
    g[4] = (tp == 2) && (st == 0) && up;
    g[5] = (tp == 2) && (st == 0) && !up;
    return g;
  endfunction

  task automatic go_level(int s);
    if (s == 1) begin err = 100; tick(); tick(); end
    else if (s == -1) begin err = -100; tick(); tick(); end
    else begin err = 0; tick(); end
  endtask

  initial begin
    int prev_topo;
    int seq [5];
    rst_n = 1'b0; err = 100; bh = 20; bd = 5; topo = 2'b00; dir = 1'b1;
    tick();
    check(lvl == 2'b00, "R12 reset level", lvl, 0);
    check(gate == 6'b0, "R12 reset gates", gate, 0);
    rst_n = 1'b1;

    // sweep of error against each prior level, two band settings, diode leg
    for (int cfg = 0; cfg < 2; cfg++) begin
      int h = (cfg == 0) ? 20 : 7;
      int d = (cfg == 0) ? 5 : 0;
      int lim = (cfg == 0) ? 30 : 10;
      bh = EW'(h); bd = EW'(d);
      for (int p = -1; p <= 1; p++) begin
        for (int e = -lim; e <= lim; e++) begin
          int ex;
          string tag;
          dir = e[0];
          go_level(p);
          err = EW'(e);
          tick();
          ex = next_lvl(p, e, h, d);
          if (e >= h && p == -1) tag = "R5";
          else if (e <= -h && p == 1) tag = "R5";
          else if (e >= h) tag = "R1";
          else if (e <= -h) tag = "R2";
          else if (e <= d && e >= -d) tag = "R3";
          else tag = "R4";
          check(lvl == bits_of(ex), tag, lvl, bits_of(ex));
          check(gate == exp_gates(0, ex, dir), "R6 sweep gates", gate, exp_gates(0, ex, dir));
        end
      end
    end

    // explicit reversal through zero
    bh = 20; bd = 5;
    go_level(1);
    err = -100; tick();
    check(lvl == 2'b00, "R5 reversal middle", lvl, 0);
    tick();
    check(lvl == 2'b11, "R5 reversal end", lvl, 3);

    // reset mid-run, no clock edge needed
    go_level(1);
    rst_n = 1'b0; #1;
    check(lvl == 2'b00, "R12 async level", lvl, 0);
    check(gate == 6'b0, "R12 async gates", gate, 0);
    tick();
    rst_n = 1'b1;

    // structure walk
    seq = '{1, 2, 3, 0, 2};
    prev_topo = 0;
    for (int k = 0; k < 5; k++) begin
      int tp = seq[k];
      string tag;
      topo = 2'(tp); err = 0; tick();
      if (tp != prev_topo) check(gate == 6'b0, "R10 blank", gate, 0);
      prev_topo = tp;
      tag = (tp == 0) ? "R6" : (tp == 1) ? "R7" : (tp == 2) ? "R8" : "R11";
      for (int dv = 0; dv < 2; dv++) begin
        dir = dv[0];
        for (int s = -1; s <= 1; s++) begin
          go_level(s);
          check(gate == exp_gates(tp, s, dir), (s == 0) ? "R9" : tag,
                gate, exp_gates(tp, s, dir));
        end
      end
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog all requirements actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule